// File: doc/BRIEF.md
# Per-Bank ECC Correction Statistics Register

This block sits beside the read path of a NAND flash controller and turns the stream of per-sector ECC decode results into a compact, read-only 32-bit status word. Each decoded sector arrives as a one-cycle strobe. The strobe carries the bank it came from, the number of bit errors the decoder corrected and a flag for a sector the decoder could not correct. While a transaction runs, the block keeps separate working statistics for each of two banks: the worst single-sector correction count seen so far, and a sticky flag that records an uncorrectable sector.

When the controller signals that the transaction is finished, the working statistics are copied into the visible word. The word then keeps those values until the next completion, so software can read the outcome of the last finished transaction at any later time. The first uncorrectable sector of a transaction also produces a single-cycle interrupt request. A separate interrupt status register receives it.

Top module: `ecc_bank_stats`

## Requirements
- R1: The status word layout is: bits 6:0 hold the bank 0 maximum count, bit 7 the bank 0 uncorrectable flag, bits 14:8 the bank 1 maximum count and bit 15 the bank 1 uncorrectable flag. Bits 31:16 always read as zero.
- R2: After a synchronous active-low reset the status word is all zero and the interrupt request is low.
- R3: The status word changes only in the cycle after `txn_done_i` is sampled high. At all other times it holds its value, whatever sector strobes or start pulses arrive.
- R4: A bank's count field equals the largest single-sector count of that bank in the committed transaction, not the sum of its counts.
- R5: `txn_start_i` clears the working count and flag of both banks. A sector strobe in the same cycle as the start belongs to the new transaction. When start and done coincide, that sector is left out of the committed values.
- R6: A sector count above 127 is clamped to 127 before it is compared. Counts 0 to 127 pass through unchanged.
- R7: A bank's uncorrectable flag is committed as 1 if any sector of that bank in the transaction carried the uncorrectable flag, even if later sectors were clean.
- R8: `uncor_irq_o` pulses high for one cycle, in the cycle after the first uncorrectable sector strobe (either bank) of a transaction. Later uncorrectable strobes in the same transaction raise no further pulse.
- R9: A sector strobe in the same cycle as `txn_done_i` (and without a start) is included in the committed values.
- R10: A bank with no sector strobes during a transaction commits a zero count and a clear flag.
- R11: A sector strobe updates only the bank selected by `sec_bank_i` (0 = bank 0, 1 = bank 1). The other bank's statistics are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| txn_start_i | input | 1 | One-cycle pulse at transaction start |
| txn_done_i | input | 1 | One-cycle pulse at transaction completion |
| sec_valid_i | input | 1 | Sector result strobe |
| sec_bank_i | input | 1 | Bank of the sector result |
| sec_errcnt_i | input | 8 | Corrected error count of the sector |
| sec_uncor_i | input | 1 | Sector was uncorrectable |
| status_o | output | 32 | Committed statistics word |
| uncor_irq_o | output | 1 | One-cycle uncorrectable interrupt request |

## Verification
Every count value from 0 to 255 is committed alone in each bank. This separates clean pass-through from clamping at 127 and shows that the other bank's field stays zero. Short directed transactions use rising, falling and repeated counts to tell a running maximum from a sum or a last-value register. Other directed cases place an uncorrectable sector first, in the middle or in both banks, which checks the sticky flag and the single interrupt pulse. The edge cycles are covered directly: a sector together with done, with start, or with both, and an empty bank. A long pseudo-random stream with random start and done pulses then compares every cycle against an arithmetic model, including the hold behaviour between completions.

// File: rtl/ecc_stats_pkg.sv
// Package: ecc_stats_pkg
// Shared defaults for the ECC statistics block. The layout gives each bank
// one slot of FIELD_W count bits plus one flag bit, packed from bit 0 upward.
package ecc_stats_pkg;
    localparam int DEF_NUM_BANKS = 2;
    localparam int DEF_CNT_IN_W  = 8;
    localparam int DEF_FIELD_W   = 7;
    localparam int DEF_STATUS_W  = 32;

    // Width of one bank slot in the status word
    function automatic int slot_width(input int field_w);
        return field_w + 1;
    endfunction
endpackage

// File: rtl/ecc_count_sat.sv
// Module: ecc_count_sat
// Fits a raw per-sector error count into the status field width by clamping
// at the largest representable value. Purely combinational.
// Assumes: OUT_W >= 1. When IN_W <= OUT_W the count is zero-extended.
module ecc_count_sat #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 7
) (
    input  logic [IN_W-1:0]  raw_i,
    output logic [OUT_W-1:0] sat_o
);
    generate
        if (IN_W > OUT_W) begin : g_clip
            localparam logic [IN_W-1:0] LIMIT = {{(IN_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};
            // Clamp values above the field range to all ones
            always_comb begin
                if (raw_i > LIMIT) sat_o = {OUT_W{1'b1}};
                else               sat_o = raw_i[OUT_W-1:0];
            end
        end else if (IN_W == OUT_W) begin : g_same
            assign sat_o = raw_i;
        end else begin : g_pad
            assign sat_o = {{(OUT_W-IN_W){1'b0}}, raw_i};
        end
    endgenerate
endmodule

// File: rtl/ecc_bank_tracker.sv
// Module: ecc_bank_tracker
// Working statistics of one bank for the running transaction: the largest
// corrected count so far and a sticky uncorrectable flag. It also offers the
// values to commit if the transaction ends this cycle.
// Assumes: hit_i is the sector strobe already decoded for this bank; a start
// in the same cycle as a hit puts that hit into the new transaction.
module ecc_bank_tracker #(
    parameter int FIELD_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               txn_start_i,
    input  logic               hit_i,
    input  logic [FIELD_W-1:0] cnt_i,
    input  logic               uncor_i,
    output logic [FIELD_W-1:0] work_max_o,
    output logic               work_unc_o,
    output logic [FIELD_W-1:0] commit_max_o,
    output logic               commit_unc_o
);
    logic [FIELD_W-1:0] work_max_q;
    logic               work_unc_q;
    logic [FIELD_W-1:0] base_max, next_max;
    logic               base_unc, next_unc;

    // Merge the current strobe into the (possibly restarted) working values
    always_comb begin
        base_max = txn_start_i ? '0   : work_max_q;
        base_unc = txn_start_i ? 1'b0 : work_unc_q;
        next_max = (hit_i && (cnt_i > base_max)) ? cnt_i : base_max;
        next_unc = base_unc | (hit_i & uncor_i);
    end

    // Working state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_max_q <= '0;
            work_unc_q <= 1'b0;
        end else begin
            work_max_q <= next_max;
            work_unc_q <= next_unc;
        end
    end

    // Commit view: a start-cycle strobe is excluded from the old transaction
    assign commit_max_o = txn_start_i ? work_max_q : next_max;
    assign commit_unc_o = txn_start_i ? work_unc_q : next_unc;
    assign work_max_o   = work_max_q;
    assign work_unc_o   = work_unc_q;

    // R4: within a transaction the working maximum never falls
    p_running_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_start_i |=> (work_max_q >= $past(work_max_q)));

    // R7: the uncorrectable flag stays set until a start
    p_sticky_unc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!txn_start_i && work_unc_q) |=> work_unc_q);

    // R5: a start without a strobe leaves the bank cleared
    p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_start_i && !hit_i) |=> (work_max_q == '0 && !work_unc_q));
endmodule

// File: rtl/ecc_status_commit.sv
// Module: ecc_status_commit
// Holds the committed per-bank statistics, packs them into the status word
// and issues the uncorrectable interrupt pulse.
// Assumes: commit_* inputs already contain any same-cycle strobe that
// belongs to the finishing transaction; work_unc_i is the registered flag.
module ecc_status_commit #(
    parameter int NUM_BANKS = 2,
    parameter int FIELD_W   = 7,
    parameter int STATUS_W  = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         txn_start_i,
    input  logic                         txn_done_i,
    input  logic                         sec_valid_i,
    input  logic                         sec_uncor_i,
    input  logic [NUM_BANKS*FIELD_W-1:0] commit_max_i,
    input  logic [NUM_BANKS-1:0]         commit_unc_i,
    input  logic [NUM_BANKS-1:0]         work_unc_i,
    output logic [STATUS_W-1:0]          status_o,
    output logic                         uncor_irq_o
);
    localparam int SLOT_W = ecc_stats_pkg::slot_width(FIELD_W);
    localparam int USED_W = NUM_BANKS * SLOT_W;

    logic [NUM_BANKS*FIELD_W-1:0] cmax_q;
    logic [NUM_BANKS-1:0]         cunc_q;
    logic                         irq_q;
    logic                         seen_unc;
    logic                         irq_event;

    // Committed statistics: load on done, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmax_q <= '0;
            cunc_q <= '0;
        end else if (txn_done_i) begin
            cmax_q <= commit_max_i;
            cunc_q <= commit_unc_i;
        end
    end

    // First-uncorrectable detection across all banks of the transaction
    always_comb begin
        seen_unc  = (|work_unc_i) && !txn_start_i;
        irq_event = sec_valid_i && sec_uncor_i && !seen_unc;
    end

    // Interrupt pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_event;
    end

    assign uncor_irq_o = irq_q;

    // Pack each bank slot: count in the low bits, flag on top
    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_slot
            assign status_o[b*SLOT_W +: FIELD_W]  = cmax_q[b*FIELD_W +: FIELD_W];
            assign status_o[b*SLOT_W + FIELD_W]   = cunc_q[b];
        end
        if (STATUS_W > USED_W) begin : g_rsvd
            assign status_o[STATUS_W-1:USED_W] = '0;
        end
    endgenerate

    // R3: without done the visible word holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_done_i |=> $stable(status_o));

    // R8: a pulse only follows an uncorrectable strobe
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        uncor_irq_o |-> $past(sec_valid_i && sec_uncor_i));
endmodule

// File: rtl/ecc_bank_stats.sv
// Module: ecc_bank_stats (top)
// Per-bank ECC correction statistics: clamps incoming sector counts, tracks
// a running maximum and sticky uncorrectable flag per bank, and commits them
// to a read-only status word on transaction completion.
// Assumes: start, done and sector strobes are single-cycle pulses in clk.
module ecc_bank_stats #(
    parameter int NUM_BANKS = ecc_stats_pkg::DEF_NUM_BANKS,
    parameter int CNT_IN_W  = ecc_stats_pkg::DEF_CNT_IN_W,
    parameter int FIELD_W   = ecc_stats_pkg::DEF_FIELD_W,
    parameter int STATUS_W  = ecc_stats_pkg::DEF_STATUS_W,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                txn_start_i,
    input  logic                txn_done_i,
    input  logic                sec_valid_i,
    input  logic [BANK_W-1:0]   sec_bank_i,
    input  logic [CNT_IN_W-1:0] sec_errcnt_i,
    input  logic                sec_uncor_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                uncor_irq_o
);
    logic [FIELD_W-1:0]           cnt_sat;
    logic [NUM_BANKS-1:0]         bank_hit;
    logic [NUM_BANKS*FIELD_W-1:0] work_max;
    logic [NUM_BANKS-1:0]         work_unc;
    logic [NUM_BANKS*FIELD_W-1:0] commit_max;
    logic [NUM_BANKS-1:0]         commit_unc;

    ecc_count_sat #(
        .IN_W  (CNT_IN_W),
        .OUT_W (FIELD_W)
    ) u_sat (
        .raw_i (sec_errcnt_i),
        .sat_o (cnt_sat)
    );

    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            // Decode the strobe for this bank
            assign bank_hit[b] = sec_valid_i && (sec_bank_i == BANK_W'(b));

            ecc_bank_tracker #(
                .FIELD_W (FIELD_W)
            ) u_trk (
                .clk          (clk),
                .rst_n        (rst_n),
                .txn_start_i  (txn_start_i),
                .hit_i        (bank_hit[b]),
                .cnt_i        (cnt_sat),
                .uncor_i      (sec_uncor_i),
                .work_max_o   (work_max[b*FIELD_W +: FIELD_W]),
                .work_unc_o   (work_unc[b]),
                .commit_max_o (commit_max[b*FIELD_W +: FIELD_W]),
                .commit_unc_o (commit_unc[b])
            );
        end
    endgenerate

    ecc_status_commit #(
        .NUM_BANKS (NUM_BANKS),
        .FIELD_W   (FIELD_W),
        .STATUS_W  (STATUS_W)
    ) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .txn_start_i  (txn_start_i),
        .txn_done_i   (txn_done_i),
        .sec_valid_i  (sec_valid_i),
        .sec_uncor_i  (sec_uncor_i),
        .commit_max_i (commit_max),
        .commit_unc_i (commit_unc),
        .work_unc_i   (work_unc),
        .status_o     (status_o),
        .uncor_irq_o  (uncor_irq_o)
    );

    // R11: at most one bank is selected by any strobe
    p_one_bank_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit));

    // R6: the clamped count never exceeds the raw count
    p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_IN_W'(cnt_sat) <= sec_errcnt_i);
endmodule

// File: tb/ecc_bank_stats_tb.sv
`timescale 1ns/1ps
module ecc_bank_stats_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start_i = 1'b0;
    logic        txn_done_i = 1'b0;
    logic        sec_valid_i = 1'b0;
    logic [0:0]  sec_bank_i = 1'b0;
    logic [7:0]  sec_errcnt_i = 8'd0;
    logic        sec_uncor_i = 1'b0;
    logic [31:0] status_o;
    logic        uncor_irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done_flag = 1'b0;

    // Bench model of the working and visible state
    int          m_wmax [2];
    bit          m_wunc [2];
    logic [31:0] m_word = 32'h0;
    bit          m_irq  = 1'b0;

    always #10 clk = ~clk;

    ecc_bank_stats u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .txn_start_i  (txn_start_i),
        .txn_done_i   (txn_done_i),
        .sec_valid_i  (sec_valid_i),
        .sec_bank_i   (sec_bank_i),
        .sec_errcnt_i (sec_errcnt_i),
        .sec_uncor_i  (sec_uncor_i),
        .status_o     (status_o),
        .uncor_irq_o  (uncor_irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, predict, sample 5 ns after the edge
    task automatic step(input bit st, input bit dn, input bit v, input int bk,
                        input int cnt, input bit un, input string tag);
        int  s;
        int  nm [2];
        bit  nu [2];
        bit  seen;
        @(negedge clk);
        txn_start_i  = st;
        txn_done_i   = dn;
        sec_valid_i  = v;
        sec_bank_i   = bk[0];
        sec_errcnt_i = cnt[7:0];
        sec_uncor_i  = un;
        s    = (cnt > 127) ? 127 : cnt;
        seen = (m_wunc[0] | m_wunc[1]) && !st;
        for (int b = 0; b < 2; b++) begin
            int base;
            bit bu;
            bit hit;
            base  = st ? 0 : m_wmax[b];
            bu    = st ? 1'b0 : m_wunc[b];
            hit   = v && (bk == b);
            nm[b] = (hit && s > base) ? s : base;
            nu[b] = bu | (hit & un);
        end
        if (dn) begin
            m_word = 32'h0;
            for (int b = 0; b < 2; b++) begin
                int cm;
                bit cu;
                cm = st ? m_wmax[b] : nm[b];
                cu = st ? m_wunc[b] : nu[b];
                m_word[b*8 +: 7] = cm[6:0];
                m_word[b*8 + 7]  = cu;
            end
        end
        m_irq = v && un && !seen;
        for (int b = 0; b < 2; b++) begin
            m_wmax[b] = nm[b];
            m_wunc[b] = nu[b];
        end
        @(posedge clk);
        #5;
        check(tag, status_o, m_word);
        check("R8", {31'h0, uncor_irq_o}, {31'h0, m_irq});
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #4_000_000;
        if (!done_flag) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        m_wmax[0] = 0; m_wmax[1] = 0;
        m_wunc[0] = 0; m_wunc[1] = 0;
        repeat (3) @(posedge clk);
        #5;
        check("R2", status_o, 32'h0);
        check("R2", {31'h0, uncor_irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6 sweep: every count alone in each bank
        for (int bk = 0; bk < 2; bk++) begin
            for (int c = 0; c < 256; c++) begin
                step(1, 0, 0, 0, 0, 0, "R5");
                step(0, 0, 1, bk, c, 0, "R3");
                step(0, 1, 0, 0, 0, 0, "R6");
            end
        end
        check("R1", {16'h0, status_o[31:16]}, 32'h0);

        // R4: maximum, not sum
        step(1, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 0, 5, 0, "R4");
        step(0, 0, 1, 1, 3, 0, "R4");
        step(0, 0, 1, 0, 30, 0, "R4");
        step(0, 0, 1, 1, 3, 0, "R4");
        step(0, 0, 1, 0, 12, 0, "R4");
        step(0, 0, 1, 1, 3, 0, "R4");
        step(0, 1, 0, 0, 0, 0, "R4");
        check("R4", status_o, 32'h0000_031E);

        // R7 / R8: sticky flag, single pulse
        step(1, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 1, 4, 0, "R7");
        step(0, 0, 1, 1, 9, 1, "R8");
        step(0, 0, 1, 1, 2, 0, "R7");
        step(0, 0, 1, 0, 1, 1, "R8");
        step(0, 0, 1, 1, 0, 1, "R8");
        step(0, 1, 0, 0, 0, 0, "R7");
        check("R7", status_o, 32'h0000_8981);

        // R10: empty bank commits zero
        step(1, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 0, 17, 0, "R10");
        step(0, 1, 0, 0, 0, 0, "R10");
        check("R10", status_o, 32'h0000_0011);

        // R9: sector with done is committed
        step(1, 0, 0, 0, 0, 0, "R5");
        step(0, 0, 1, 1, 6, 0, "R9");
        step(0, 1, 1, 1, 40, 1, "R9");
        check("R9", status_o, 32'h0000_A800);

        // R3: strobes without done leave the word alone
        step(0, 0, 1, 0, 99, 1, "R3");
        step(1, 0, 1, 1, 77, 0, "R3");
        idle("R3");
        check("R3", status_o, 32'h0000_A800);

        // R5: start+done with a strobe, strobe goes to new transaction
        step(0, 0, 1, 0, 20, 0, "R5");
        step(1, 1, 1, 0, 50, 1, "R5");
        step(0, 1, 0, 0, 0, 0, "R5");
        check("R5", status_o, 32'h0000_00B2);

        // R11: pseudo-random stream against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            step(r < 8, r >= 90, $urandom_range(0, 3) != 0, $urandom_range(0, 1),
                 $urandom_range(0, 255), $urandom_range(0, 15) == 0, "R11");
        end

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule